// File: doc/BRIEF.md
# Operand Effective Address Generator

This block forms the 16-bit operand address for a small 8-bit accumulator processor. A decoder pulses `start_i` together with an addressing-mode code. The block then takes the offset or address bytes that the fetch unit delivers one at a time, marked by `byte_vld_i`, from the instruction stream. When it has enough bytes, it presents the address on `ea_o` and raises `ea_done_o` for exactly one cycle.

The base is either the 16-bit index pair (H:X) or the stack pointer. Both base values are captured at `start_i`. Offsets are added with plain 16-bit wrap-around, and no carry or flag is produced. Two modes also step the index pair. Once an external acknowledge `opnd_ack_i` reports that the operand has been read, the block returns the captured H:X plus one on `hx_wb_o`, together with a one-cycle enable. The asynchronous reset is released to the logic through a two-flop synchronizer.

Top module: `opnd_ea_gen`

## Requirements
- R1: Mode code 0 (absolute) consumes two bytes, and the first byte becomes address bits 15:8, the second bits 7:0.
- R2: Mode code 1 (index, no offset) consumes no byte, and `ea_done_o` rises in the cycle after `start_i` with `ea_o` equal to H:X.
- R3: Mode code 3 consumes one byte and yields H:X plus that byte zero-extended to 16 bits.
- R4: Mode code 5 consumes two bytes, high byte first, and yields H:X plus that 16-bit offset.
- R5: Mode code 6 consumes one byte and yields SP plus that byte zero-extended.
- R6: Mode code 7 consumes two bytes, high byte first, and yields SP plus that 16-bit offset.
- R7: Every addition and the index increment wrap modulo 2^16.
- R8: `ea_done_o` is high for exactly one cycle. That cycle follows the clock edge that accepted the last needed byte, or follows `start_i` in mode 1 or 2. Idle cycles between bytes delay it.
- R9: Byte strobes are ignored while no request is in progress, and `start_i` is ignored while a request is in progress.
- R10: Mode code 2 yields H:X, and mode code 4 consumes one byte and yields H:X plus the zero-extended byte. In both modes, `hx_wb_en_o` is high for one cycle in the cycle after the first `opnd_ack_i` seen from the done cycle onward, with `hx_wb_o` equal to the captured H:X plus one, not the address plus one.
- R11: `hx_wb_en_o` never rises in modes 0, 1, 3, 5, 6 or 7, even when `opnd_ack_i` is high.
- R12: After reset, `ea_done_o` and `hx_wb_en_o` are low and `ea_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an address computation |
| mode_i | input | 3 | Addressing-mode code, sampled with `start_i` |
| hx_i | input | 16 | Current index pair H:X, sampled with `start_i` |
| sp_i | input | 16 | Current stack pointer, sampled with `start_i` |
| byte_vld_i | input | 1 | Instruction byte strobe |
| byte_i | input | 8 | Instruction byte |
| opnd_ack_i | input | 1 | Operand has been fetched |
| ea_o | output | 16 | Effective address, valid while `ea_done_o` is high |
| ea_done_o | output | 1 | One-cycle completion strobe |
| hx_wb_o | output | 16 | Incremented index pair |
| hx_wb_en_o | output | 1 | One-cycle write-back enable for H:X |

## Verification
If the remaining-byte counter is corrupted, `ea_done_o` shows up one or more byte strobes early or late. The bench catches this by checking that the strobe stays low through deliberate gaps between bytes and is high in exactly one cycle. If the operand shift register is corrupted, the bytes land in the wrong halves or stale high bits survive into an 8-bit offset, and `ea_o` is wrong in the done cycle itself. If the write-back path is wrong, `hx_wb_en_o` fires without an acknowledge, fires in a non-incrementing mode, or carries the address plus one instead of H:X plus one. Each of these is visible within one cycle of the acknowledge.

// File: rtl/oeag_pkg.sv
package oeag_pkg;

  typedef enum logic [2:0] {
    M_ABS    = 3'd0,
    M_IX     = 3'd1,
    M_IXP    = 3'd2,
    M_IX8    = 3'd3,
    M_IX8P   = 3'd4,
    M_IX16   = 3'd5,
    M_SP8    = 3'd6,
    M_SP16   = 3'd7
  } ea_mode_e;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_GATHER = 3'd1,
    S_DONE   = 3'd2,
    S_WAIT   = 3'd3,
    S_WB     = 3'd4
  } ea_state_e;

  function automatic logic [1:0] need_bytes(ea_mode_e m);
    case (m)
      M_ABS, M_IX16, M_SP16: need_bytes = 2'd2;
      M_IX, M_IXP:           need_bytes = 2'd0;
      default:               need_bytes = 2'd1;
    endcase
  endfunction

  function automatic logic is_pinc(ea_mode_e m);
    is_pinc = (m == M_IXP) || (m == M_IX8P);
  endfunction

  function automatic logic uses_sp(ea_mode_e m);
    uses_sp = (m == M_SP8) || (m == M_SP16);
  endfunction

endpackage

// File: rtl/oeag_rst_sync.sv
module oeag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/oeag_ctrl.sv
module oeag_ctrl
  import oeag_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  ea_mode_e          mode_i,
  input  logic [ADDR_W-1:0] hx_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic              byte_vld_i,
  input  logic              opnd_ack_i,
  output ea_mode_e          mode_q_o,
  output logic [ADDR_W-1:0] hx_q_o,
  output logic [ADDR_W-1:0] sp_q_o,
  output logic              gather_en_o,
  output logic              clr_o,
  output logic              done_o,
  output logic              wb_load_o,
  output logic              wb_en_o
);
  ea_state_e         state_q, state_d;
  logic [1:0]        cnt_q, cnt_d;
  logic              cap_en;
  ea_mode_e          mode_q;
  logic [ADDR_W-1:0] hx_q, sp_q;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    cap_en    = 1'b0;
    wb_load_o = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start_i) begin
          cap_en  = 1'b1;
          cnt_d   = need_bytes(mode_i);
          state_d = (need_bytes(mode_i) == 2'd0) ? S_DONE : S_GATHER;
        end
      end
      S_GATHER: begin
        if (byte_vld_i) begin
          cnt_d = cnt_q - 2'd1;
          if (cnt_q == 2'd1) state_d = S_DONE;
        end
      end
      S_DONE: begin
        if (is_pinc(mode_q)) begin
          if (opnd_ack_i) begin
            state_d   = S_WB;
            wb_load_o = 1'b1;
          end else begin
            state_d = S_WAIT;
          end
        end else begin
          state_d = S_IDLE;
        end
      end
      S_WAIT: begin
        if (opnd_ack_i) begin
          state_d   = S_WB;
          wb_load_o = 1'b1;
        end
      end
      S_WB:    state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= 2'd0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_ABS;
      hx_q   <= '0;
      sp_q   <= '0;
    end else if (cap_en) begin
      mode_q <= mode_i;
      hx_q   <= hx_i;
      sp_q   <= sp_i;
    end
  end

  assign mode_q_o    = mode_q;
  assign hx_q_o      = hx_q;
  assign sp_q_o      = sp_q;
  assign clr_o       = cap_en;
  assign gather_en_o = (state_q == S_GATHER);
  assign done_o      = (state_q == S_DONE);
  assign wb_en_o     = (state_q == S_WB);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_nobyte_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && start_i && need_bytes(mode_i) == 2'd0) |=> done_o);

  assert_wb_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |=> !wb_en_o);

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) |=> $stable(mode_q) && $stable(hx_q) && $stable(sp_q));
endmodule

// File: rtl/oeag_opnd_shift.sv
module oeag_opnd_shift #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr_i,
  input  logic                        gather_en_i,
  input  logic                        byte_vld_i,
  input  logic [BYTE_W-1:0]           byte_i,
  output logic [NUM_BYTES*BYTE_W-1:0] opnd_o
);
  logic [BYTE_W-1:0] lane_q [NUM_BYTES];
  logic              shift_en;

  assign shift_en = clr_i || (gather_en_i && byte_vld_i);

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_d;
    if (g == 0) begin : g_first
      assign lane_d = clr_i ? '0 : byte_i;
    end else begin : g_next
      assign lane_d = clr_i ? '0 : lane_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lane_q[g] <= '0;
      else if (shift_en) lane_q[g] <= lane_d;
    end
    assign opnd_o[g*BYTE_W +: BYTE_W] = lane_q[g];
  end

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!gather_en_i && !clr_i) |=> $stable(opnd_o));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (opnd_o == '0));
endmodule

// File: rtl/oeag_addr_calc.sv
module oeag_addr_calc
  import oeag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  ea_mode_e          mode_i,
  input  logic [ADDR_W-1:0] hx_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [ADDR_W-1:0] opnd_i,
  output logic [ADDR_W-1:0] ea_o
);
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] off8;

  assign base = uses_sp(mode_i) ? sp_i : hx_i;
  assign off8 = {{(ADDR_W-BYTE_W){1'b0}}, opnd_i[BYTE_W-1:0]};

  always_comb begin
    case (mode_i)
      M_ABS:                  ea_o = opnd_i;
      M_IX, M_IXP:            ea_o = base;
      M_IX8, M_IX8P, M_SP8:   ea_o = base + off8;
      default:                ea_o = base + opnd_i;
    endcase
  end
endmodule

// File: rtl/oeag_hx_incr.sv
module oeag_hx_incr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] hx_i,
  output logic [ADDR_W-1:0] hx_wb_o
);
  logic [ADDR_W-1:0] wb_q, wb_d;

  assign wb_d = hx_i + {{(ADDR_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wb_q <= '0;
    else if (load_i) wb_q <= wb_d;
  end

  assign hx_wb_o = wb_q;
endmodule

// File: rtl/opnd_ea_gen.sv
module opnd_ea_gen
  import oeag_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] hx_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              opnd_ack_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              ea_done_o,
  output logic [ADDR_W-1:0] hx_wb_o,
  output logic              hx_wb_en_o
);
  localparam int NUM_BYTES = ADDR_W / BYTE_W;

  logic              rst_sync_n;
  ea_mode_e          mode_q;
  logic [ADDR_W-1:0] hx_q, sp_q, opnd;
  logic              gather_en, clr, wb_load;

  oeag_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  oeag_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .start_i(start_i),
    .mode_i(ea_mode_e'(mode_i)), .hx_i(hx_i), .sp_i(sp_i),
    .byte_vld_i(byte_vld_i), .opnd_ack_i(opnd_ack_i),
    .mode_q_o(mode_q), .hx_q_o(hx_q), .sp_q_o(sp_q),
    .gather_en_o(gather_en), .clr_o(clr), .done_o(ea_done_o),
    .wb_load_o(wb_load), .wb_en_o(hx_wb_en_o)
  );

  oeag_opnd_shift #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_shift (
    .clk(clk), .rst_n(rst_sync_n), .clr_i(clr), .gather_en_i(gather_en),
    .byte_vld_i(byte_vld_i), .byte_i(byte_i), .opnd_o(opnd)
  );

  oeag_addr_calc #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_calc (
    .mode_i(mode_q), .hx_i(hx_q), .sp_i(sp_q), .opnd_i(opnd), .ea_o(ea_o)
  );

  oeag_hx_incr #(.ADDR_W(ADDR_W)) u_incr (
    .clk(clk), .rst_n(rst_sync_n), .load_i(wb_load), .hx_i(hx_q),
    .hx_wb_o(hx_wb_o)
  );

  assert_ix_addr_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ea_done_o && (mode_q == M_IX || mode_q == M_IXP)) |-> (ea_o == hx_q));

  assert_wb_only_pinc_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hx_wb_en_o |-> is_pinc(mode_q));

  assert_wb_value_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hx_wb_en_o |-> (hx_wb_o == hx_q + {{(ADDR_W-1){1'b0}}, 1'b1}));

  assert_wb_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(hx_wb_en_o) |-> $past(opnd_ack_i));
endmodule

// File: tb/test_opnd_ea_gen.sv
module test_opnd_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, byte_vld_i, opnd_ack_i;
  logic [2:0]  mode_i;
  logic [15:0] hx_i, sp_i;
  logic [7:0]  byte_i;
  logic [15:0] ea_o, hx_wb_o;
  logic        ea_done_o, hx_wb_en_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  opnd_ea_gen i_opnd_ea_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .hx_i(hx_i), .sp_i(sp_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .opnd_ack_i(opnd_ack_i), .ea_o(ea_o), .ea_done_o(ea_done_o),
    .hx_wb_o(hx_wb_o), .hx_wb_en_o(hx_wb_en_o)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(logic [2:0] m);
    if (m == 3'd0 || m == 3'd5 || m == 3'd7) return 2;
    if (m == 3'd1 || m == 3'd2) return 0;
    return 1;
  endfunction

  // Issue a request, feed bytes with 'gap' idle cycles before each, and
  // stop on the negedge where done must be high.
  task automatic run_op(string tag, logic [2:0] m, logic [15:0] hx, logic [15:0] sp,
                        logic [7:0] b0, logic [7:0] b1, int gap, logic [15:0] exp);
    mode_i = m; hx_i = hx; sp_i = sp; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < nbytes(m); i++) begin
      for (int k = 0; k < gap; k++) begin
        chk({tag, " R8 early done"}, 16'(ea_done_o), 16'd0);
        @(negedge clk);
      end
      byte_vld_i = 1'b1;
      byte_i = (i == 0) ? b0 : b1;
      @(negedge clk);
      byte_vld_i = 1'b0;
    end
    chk({tag, " R8 done"}, 16'(ea_done_o), 16'd1);
    chk({tag, " addr"}, ea_o, exp);
  endtask

  task automatic after_done(string tag);
    @(negedge clk);
    chk({tag, " R8 single pulse"}, 16'(ea_done_o), 16'd0);
  endtask

  task automatic t_reset;
    chk("R12 done", 16'(ea_done_o), 16'd0);
    chk("R12 wb_en", 16'(hx_wb_en_o), 16'd0);
    chk("R12 ea", ea_o, 16'h0000);
  endtask

  task automatic t_abs;
    run_op("R1 abs", 3'd0, 16'h1111, 16'h2222, 8'h12, 8'h34, 0, 16'h1234);
    after_done("R1 abs");
  endtask

  task automatic t_ix;
    run_op("R2 ix", 3'd1, 16'hBEEF, 16'h0100, 8'h00, 8'h00, 0, 16'hBEEF);
    after_done("R2 ix");
  endtask

  task automatic t_ix8;
    run_op("R3 ix8", 3'd3, 16'h1000, 16'h0100, 8'hF0, 8'h00, 1, 16'h10F0);
    after_done("R3 ix8");
  endtask

  task automatic t_ix16;
    run_op("R4 ix16", 3'd5, 16'h0102, 16'h0100, 8'h30, 8'h04, 2, 16'h3106);
    after_done("R4 ix16");
  endtask

  task automatic t_sp8;
    run_op("R5 sp8", 3'd6, 16'h5555, 16'h00FF, 8'h81, 8'h00, 0, 16'h0180);
    after_done("R5 sp8");
  endtask

  task automatic t_sp16;
    run_op("R6 sp16", 3'd7, 16'h5555, 16'h0200, 8'h10, 8'h01, 1, 16'h1201);
    after_done("R6 sp16");
  endtask

  task automatic t_wrap;
    run_op("R7 ix16 wrap", 3'd5, 16'hF000, 16'h0, 8'h23, 8'h45, 0, 16'h1345);
    after_done("R7 ix16 wrap");
    run_op("R7 sp8 wrap", 3'd6, 16'h0, 16'hFFF0, 8'h20, 8'h00, 0, 16'h0010);
    after_done("R7 sp8 wrap");
    run_op("R7 ix8p wrap", 3'd4, 16'hFFFF, 16'h0, 8'h01, 8'h00, 0, 16'h0000);
    opnd_ack_i = 1'b1;
    @(negedge clk);
    opnd_ack_i = 1'b0;
    chk("R7 wb wrap en", 16'(hx_wb_en_o), 16'd1);
    chk("R7 wb wrap value", hx_wb_o, 16'h0000);
    @(negedge clk);
  endtask

  task automatic t_pinc_late_ack;
    run_op("R10 ixp", 3'd2, 16'h1234, 16'h0, 8'h00, 8'h00, 0, 16'h1234);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 no wb before ack", 16'(hx_wb_en_o), 16'd0);
    end
    opnd_ack_i = 1'b1;
    @(negedge clk);
    opnd_ack_i = 1'b0;
    chk("R10 wb en", 16'(hx_wb_en_o), 16'd1);
    chk("R10 wb value", hx_wb_o, 16'h1235);
    @(negedge clk);
    chk("R10 wb pulse", 16'(hx_wb_en_o), 16'd0);
  endtask

  task automatic t_pinc_early_ack;
    run_op("R10 ix8p", 3'd4, 16'h2000, 16'h0, 8'h80, 8'h00, 0, 16'h2080);
    opnd_ack_i = 1'b1;
    @(negedge clk);
    opnd_ack_i = 1'b0;
    chk("R10 ix8p wb en", 16'(hx_wb_en_o), 16'd1);
    chk("R10 ix8p wb is hx+1", hx_wb_o, 16'h2001);
    @(negedge clk);
    chk("R10 ix8p wb pulse", 16'(hx_wb_en_o), 16'd0);
  endtask

  task automatic t_no_wb;
    opnd_ack_i = 1'b1;
    run_op("R11 ix8 ack", 3'd3, 16'h3000, 16'h0, 8'h01, 8'h00, 0, 16'h3001);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 no wb", 16'(hx_wb_en_o), 16'd0);
    end
    opnd_ack_i = 1'b0;
  endtask

  task automatic t_idle_bytes;
    for (int k = 0; k < 3; k++) begin
      byte_vld_i = 1'b1; byte_i = 8'h77;
      @(negedge clk);
      chk("R9 idle bytes no done", 16'(ea_done_o), 16'd0);
    end
    byte_vld_i = 1'b0;
    run_op("R9 after idle bytes", 3'd0, 16'h0, 16'h0, 8'hAB, 8'hCD, 0, 16'hABCD);
    after_done("R9 after idle bytes");
  endtask

  task automatic t_busy_start;
    mode_i = 3'd0; hx_i = 16'h0; sp_i = 16'h0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    byte_vld_i = 1'b1; byte_i = 8'h56;
    @(negedge clk);
    byte_vld_i = 1'b0;
    mode_i = 3'd1; hx_i = 16'h9999; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R9 busy start no done", 16'(ea_done_o), 16'd0);
    byte_vld_i = 1'b1; byte_i = 8'h78;
    @(negedge clk);
    byte_vld_i = 1'b0;
    chk("R9 busy start done", 16'(ea_done_o), 16'd1);
    chk("R9 busy start addr", ea_o, 16'h5678);
    after_done("R9 busy start");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog R8 actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; byte_vld_i = 1'b0; opnd_ack_i = 1'b0;
    mode_i = 3'd0; hx_i = 16'h0; sp_i = 16'h0; byte_i = 8'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_abs();
    t_ix();
    t_ix8();
    t_ix16();
    t_sp8();
    t_sp16();
    t_wrap();
    t_pinc_late_ack();
    t_pinc_early_ack();
    t_no_wb();
    t_idle_bytes();
    t_busy_start();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule